// File: doc/BRIEF.md
# Ping-Pong Scan Result Buffer

This block holds converter results for a multichannel scan in two banks that trade places. A sequencer fills the writable bank one channel word at a time and then pulses a scan-complete strobe. While it does so, the host drains the other bank through a simple word-at-a-time read port that stands in for a serial link. At the end of each scan the banks exchange roles and an active-low end-of-scan interrupt is raised. The first word the host reads clears it.

When the host falls behind, the outcome depends on how far its read has got. If the host has not yet touched the pending scan, the banks swap anyway, so the older unread scan is replaced by the newer one. If the host is part-way through a read, the banks stay where they are. The scan being written is then overwritten by the next one, and the data the host is reading stays intact.

Top module: `pingpong_scan_buf`

## Requirements
- R1: After reset the readable bank is bank 1 (`rd_bank_o` = 1), `eos_no` is high and `rd_data_o` reads 0 (both banks clear to zero).
- R2: An accepted write stores `wr_data_i` at word `wr_ch_i` of the writable bank, which is always the bank other than `rd_bank_o`. The written data does not appear on `rd_data_o` until a swap makes that bank readable.
- R3: A `scan_done_i` pulse while no read session is in progress toggles `rd_bank_o`, drives `eos_no` low and rewinds the read pointer to word 0. All three are visible in the cycle after the pulse.
- R4: `rd_data_o` shows, combinationally, the word at the read pointer of the readable bank. Each `rd_en_i` strobe advances the pointer by one. The first strobe after a swap starts the read session and drives `eos_no` high from the next cycle.
- R5: A session ends on a `rd_done_i` pulse or on a strobe at the last active word. A later `scan_done_i` then swaps normally and no scan is lost.
- R6: If no word has been read since the last swap, `scan_done_i` still swaps and `eos_no` stays low. The unread scan is replaced by the newer one.
- R7: While a session is in progress, `scan_done_i` leaves `rd_bank_o`, the read pointer and `eos_no` unchanged. Later writes overwrite the scan held in the writable bank.
- R8: A write with `wr_ch_i` at or above the active-channel count is ignored, and the word it addresses keeps its previous value.
- R9: `rd_start_i` rewinds the read pointer to word 0 without ending or starting a session.
- R10: The read pointer never advances past the last active word. Further strobes keep showing that word.
- R11: `active_ch_i` (1 to NUM_CH; 0 or larger values mean NUM_CH) sets the last active word index to `active_ch_i`-1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| active_ch_i | input | 4 | Number of active channels, 1 to 8 |
| wr_en_i | input | 1 | Write strobe from the sequencer |
| wr_ch_i | input | 3 | Channel index of the write |
| wr_data_i | input | 16 | Conversion result |
| scan_done_i | input | 1 | Scan-complete strobe |
| rd_start_i | input | 1 | Rewind the read pointer to word 0 |
| rd_en_i | input | 1 | Read strobe, advances the read pointer |
| rd_done_i | input | 1 | Host signals the end of its read |
| rd_data_o | output | 16 | Word at the read pointer of the readable bank |
| rd_bank_o | output | 1 | Index of the bank currently readable |
| eos_no | output | 1 | End-of-scan interrupt, active low |

## Verification
A wrong session state shows at the ports on the next `scan_done_i`. A swap that should have been held makes `rd_data_o` jump to new data in the middle of a read, and a held swap that should have gone through leaves `rd_bank_o` unchanged and `eos_no` high. A bad read pointer shows on `rd_data_o` within one strobe, because the expected word at each position is distinct. A write landing in the wrong bank or word stays hidden until the following swap, so the bench reads full scans after every swap, and reads words above the active count after the count is raised.

// File: rtl/scan_buf_pkg.sv
package scan_buf_pkg;
  typedef enum logic [1:0] {
    SESS_IDLE   = 2'd0,
    SESS_ACTIVE = 2'd1,
    SESS_DONE   = 2'd2
  } sess_e;
endpackage

// File: rtl/scan_bank_mem.sv
module scan_bank_mem #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_bank_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              rd_bank_i,
  input  logic [CH_W-1:0]   rd_ch_i,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [1:0][DATA_W-1:0] bank_rd;

  for (genvar b = 0; b < 2; b++) begin : g_bank
    logic [DATA_W-1:0] word_q [NUM_CH];
    logic              sel;
    assign sel = wr_en_i && (wr_bank_i == 1'(b));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        for (int i = 0; i < NUM_CH; i++) word_q[i] <= '0;
      end else if (sel) begin
        word_q[wr_ch_i] <= wr_data_i;
      end
    end

    assign bank_rd[b] = word_q[rd_ch_i];
  end

  assign rd_data_o = bank_rd[rd_bank_i];
endmodule

// File: rtl/scan_rd_ctrl.sv
module scan_rd_ctrl
  import scan_buf_pkg::*;
#(
  parameter int NUM_CH = 8,
  localparam int CH_W  = $clog2(NUM_CH)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic            swap_i,
  input  logic            rd_start_i,
  input  logic            rd_en_i,
  input  logic            rd_done_i,
  input  logic [CH_W-1:0] last_ch_i,
  output logic [CH_W-1:0] rd_ptr_o,
  output logic            first_rd_o,
  output logic            sess_active_o
);
  sess_e           state_q;
  logic [CH_W-1:0] ptr_q;
  logic            at_last;

  assign at_last       = (ptr_q >= last_ch_i);
  assign first_rd_o    = rd_en_i && (state_q == SESS_IDLE);
  assign sess_active_o = (state_q == SESS_ACTIVE);
  assign rd_ptr_o      = ptr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q   <= '0;
      state_q <= SESS_IDLE;
    end else if (swap_i) begin
      ptr_q   <= '0;
      state_q <= SESS_IDLE;
    end else begin
      if (rd_start_i)                ptr_q <= '0;
      else if (rd_en_i && !at_last)  ptr_q <= ptr_q + 1'b1;

      unique case (state_q)
        SESS_IDLE:   if (rd_en_i) state_q <= at_last ? SESS_DONE : SESS_ACTIVE;
        SESS_ACTIVE: if (rd_done_i || (rd_en_i && at_last)) state_q <= SESS_DONE;
        default:     state_q <= SESS_DONE;
      endcase
    end
  end

  // R5: a done pulse mid-session closes it
  a_r5_done_closes: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == SESS_ACTIVE && rd_done_i && !swap_i) |=> (state_q == SESS_DONE));
  // R9: rewind lands on word 0
  a_r9_start_rewinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_start_i && !swap_i) |=> (ptr_q == '0));
  // R10: pointer holds at last active word
  a_r10_ptr_holds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && !rd_start_i && !swap_i && ptr_q == last_ch_i) |=> $stable(ptr_q));
endmodule

// File: rtl/scan_swap_ctrl.sv
module scan_swap_ctrl (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic scan_done_i,
  input  logic sess_active_i,
  input  logic first_rd_i,
  output logic swap_o,
  output logic rd_bank_o,
  output logic eos_no
);
  logic bank_q, eos_nq;

  // hold banks while a read is part-way through
  assign swap_o    = scan_done_i && !sess_active_i;
  assign rd_bank_o = bank_q;
  assign eos_no    = eos_nq;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bank_q <= 1'b1;
      eos_nq <= 1'b1;
    end else if (swap_o) begin
      bank_q <= ~bank_q;
      eos_nq <= 1'b0;
    end else if (first_rd_i) begin
      eos_nq <= 1'b1;
    end
  end

  // R3: swap raises the interrupt
  a_r3_eos_after_swap: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_i && !sess_active_i |=> !eos_no);
  // R4: first read clears it
  a_r4_first_rd_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    first_rd_i && !scan_done_i |=> eos_no);
  // R7: in-progress read pins the banks
  a_r7_hold_banks: assert property (@(posedge clk_i) disable iff (!rst_ni)
    scan_done_i && sess_active_i |=> $stable(rd_bank_o) && $stable(eos_no));
endmodule

// File: rtl/pingpong_scan_buf.sv
module pingpong_scan_buf #(
  parameter int NUM_CH = 8,
  parameter int DATA_W = 16,
  localparam int CH_W  = $clog2(NUM_CH),
  localparam int CNT_W = $clog2(NUM_CH + 1)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [CNT_W-1:0]  active_ch_i,
  input  logic              wr_en_i,
  input  logic [CH_W-1:0]   wr_ch_i,
  input  logic [DATA_W-1:0] wr_data_i,
  input  logic              scan_done_i,
  input  logic              rd_start_i,
  input  logic              rd_en_i,
  input  logic              rd_done_i,
  output logic [DATA_W-1:0] rd_data_o,
  output logic              rd_bank_o,
  output logic              eos_no
);
  logic [CH_W-1:0] last_ch, rd_ptr;
  logic            wr_ok, swap, first_rd, sess_active;

  always_comb begin
    if (active_ch_i == '0 || active_ch_i > CNT_W'(NUM_CH)) last_ch = CH_W'(NUM_CH - 1);
    else                                                   last_ch = CH_W'(active_ch_i - 1'b1);
  end

  assign wr_ok = wr_en_i && (wr_ch_i <= last_ch);

  scan_swap_ctrl u_swap (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .scan_done_i   (scan_done_i),
    .sess_active_i (sess_active),
    .first_rd_i    (first_rd),
    .swap_o        (swap),
    .rd_bank_o     (rd_bank_o),
    .eos_no        (eos_no)
  );

  scan_rd_ctrl #(.NUM_CH(NUM_CH)) u_rd (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .swap_i        (swap),
    .rd_start_i    (rd_start_i),
    .rd_en_i       (rd_en_i),
    .rd_done_i     (rd_done_i),
    .last_ch_i     (last_ch),
    .rd_ptr_o      (rd_ptr),
    .first_rd_o    (first_rd),
    .sess_active_o (sess_active)
  );

  scan_bank_mem #(.NUM_CH(NUM_CH), .DATA_W(DATA_W)) u_mem (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_ok),
    .wr_bank_i (~rd_bank_o),
    .wr_ch_i   (wr_ch_i),
    .wr_data_i (wr_data_i),
    .rd_bank_i (rd_bank_o),
    .rd_ch_i   (rd_ptr),
    .rd_data_o (rd_data_o)
  );

  // R3: swap rewinds the reader
  a_r3_swap_rewinds: assert property (@(posedge clk_i) disable iff (!rst_ni)
    swap |=> (rd_ptr == '0) && (rd_bank_o != $past(rd_bank_o)));
  // R11: pointer stays within the active range unless the count shrank
  a_r11_ptr_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $stable(active_ch_i) && $past(rd_ptr <= last_ch) |-> (rd_ptr <= last_ch));
endmodule

// File: tb/pingpong_scan_buf_tb.sv
module pingpong_scan_buf_tb;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic [3:0]  active_ch_i = 4'd8;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_ch_i = '0;
  logic [15:0] wr_data_i = '0;
  logic        scan_done_i = 1'b0;
  logic        rd_start_i = 1'b0;
  logic        rd_en_i = 1'b0;
  logic        rd_done_i = 1'b0;
  logic [15:0] rd_data_o;
  logic        rd_bank_o;
  logic        eos_no;

  int checks = 0;
  int errors = 0;
  logic exp_bank = 1'b1;

  localparam logic [15:0] BASES [4] = '{16'h1000, 16'h2200, 16'hA5A0, 16'h4440};

  always #10 clk = ~clk;

  pingpong_scan_buf u_dut (
    .clk_i(clk), .rst_ni(rst_ni), .active_ch_i(active_ch_i),
    .wr_en_i(wr_en_i), .wr_ch_i(wr_ch_i), .wr_data_i(wr_data_i),
    .scan_done_i(scan_done_i), .rd_start_i(rd_start_i), .rd_en_i(rd_en_i),
    .rd_done_i(rd_done_i), .rd_data_o(rd_data_o), .rd_bank_o(rd_bank_o), .eos_no(eos_no)
  );

  task automatic chk(input bit ok, input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic chk_data(input logic [15:0] exp, input string req);
    chk(rd_data_o === exp, req, rd_data_o, exp);
  endtask
  task automatic chk_eos(input logic exp, input string req);
    chk(eos_no === exp, req, 16'(eos_no), 16'(exp));
  endtask
  task automatic chk_bank(input string req);
    chk(rd_bank_o === exp_bank, req, 16'(rd_bank_o), 16'(exp_bank));
  endtask

  task automatic wr_scan(input logic [15:0] base);
    for (int i = 0; i < 8; i++) begin
      wr_en_i = 1'b1; wr_ch_i = 3'(i); wr_data_i = base + 16'(i);
      @(negedge clk);
    end
    wr_en_i = 1'b0;
  endtask

  task automatic pulse_done(input bit swaps);
    scan_done_i = 1'b1;
    @(negedge clk);
    scan_done_i = 1'b0;
    if (swaps) exp_bank = ~exp_bank;
  endtask

  task automatic rd_word(input logic [15:0] exp, input string req);
    chk_data(exp, req);
    rd_en_i = 1'b1;
    @(negedge clk);
    rd_en_i = 1'b0;
  endtask

  task automatic pulse(ref logic s);
    s = 1'b1;
    @(negedge clk);
    s = 1'b0;
  endtask

  initial begin
    #(20 * 150000);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    logic [15:0] prev_last;
    repeat (2) @(negedge clk);
    rst_ni = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk_bank("R1 bank");
    chk_eos(1'b1, "R1 eos");
    chk_data(16'h0000, "R1 data");

    // table walk: normal full reads, R2/R3/R4/R10
    prev_last = 16'h0000;
    for (int v = 0; v < 4; v++) begin
      wr_scan(BASES[v]);
      chk_data(prev_last, "R2 write hidden before swap");
      pulse_done(1'b1);
      chk_bank("R3 swap");
      chk_eos(1'b0, "R3 eos low");
      rd_word(BASES[v], "R4 word0");
      chk_eos(1'b1, "R4 eos cleared");
      for (int i = 1; i < 8; i++) rd_word(BASES[v] + 16'(i), "R4 word");
      rd_word(BASES[v] + 16'd7, "R10 held at last");
      chk_data(BASES[v] + 16'd7, "R10 held after extra");
      prev_last = BASES[v] + 16'd7;
    end

    // R5: session closed by rd_done, next scan swaps
    wr_scan(16'h3000); pulse_done(1'b1);
    rd_word(16'h3000, "R5 b0"); rd_word(16'h3001, "R5 b1");
    pulse(rd_done_i);
    wr_scan(16'h3100); pulse_done(1'b1);
    chk_bank("R5 swap after done");
    chk_eos(1'b0, "R5 eos");
    for (int i = 0; i < 8; i++) rd_word(16'h3100 + 16'(i), "R5 no loss");

    // R6: unread scan replaced
    wr_scan(16'h4000); pulse_done(1'b1);
    chk_eos(1'b0, "R6 eos first");
    wr_scan(16'h4100); pulse_done(1'b1);
    chk_bank("R6 swapped again");
    chk_eos(1'b0, "R6 eos still low");
    chk_data(16'h4100, "R6 newer scan");
    for (int i = 0; i < 8; i++) rd_word(16'h4100 + 16'(i), "R6 read");

    // R7: mid-read overrun keeps banks
    wr_scan(16'h5000); pulse_done(1'b1);
    rd_word(16'h5000, "R7 f0"); rd_word(16'h5001, "R7 f1");
    wr_scan(16'h5100); pulse_done(1'b0);
    chk_bank("R7 bank held");
    chk_eos(1'b1, "R7 eos stays high");
    chk_data(16'h5002, "R7 pointer kept");
    wr_scan(16'h5200);
    pulse(rd_done_i);
    pulse_done(1'b1);
    chk_bank("R7 swap after done");
    chk_data(16'h5200, "R7 newer overwrote");

    // R9: rewind mid-session
    rd_word(16'h5200, "R9 w0"); rd_word(16'h5201, "R9 w1");
    pulse(rd_start_i);
    chk_data(16'h5200, "R9 rewound");
    pulse(rd_done_i);

    // R8/R11: reduced channel count
    wr_scan(16'h6000); pulse_done(1'b1);
    for (int i = 0; i < 8; i++) rd_word(16'h6000 + 16'(i), "R8 prep a");
    wr_scan(16'h6100); pulse_done(1'b1);
    for (int i = 0; i < 8; i++) rd_word(16'h6100 + 16'(i), "R8 prep b");
    active_ch_i = 4'd3;
    wr_scan(16'h7000); pulse_done(1'b1);
    rd_word(16'h7000, "R11 a0"); rd_word(16'h7001, "R11 a1"); rd_word(16'h7002, "R11 a2");
    chk_data(16'h7002, "R11 held at count-1");
    active_ch_i = 4'd8;
    @(negedge clk);
    rd_en_i = 1'b1; @(negedge clk); rd_en_i = 1'b0;
    chk_data(16'h6003, "R8 ignored write");
    pulse_done(1'b1);
    chk_bank("R11 session ended at last active word");
    chk_eos(1'b0, "R11 eos");

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule